// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block produces the raster timing for a parallel RGB panel from a set of programmed fields. From a system clock it derives a pixel clock enable, through a divider that can be bypassed. On each pixel enable it advances a horizontal and a vertical counter. Both axes pass through four segments in a fixed order: sync, back porch, active, front porch. Every segment length is programmed as its real count minus one.

The block decodes hsync, vsync, data-enable, a pixel clock strobe and the active-area pixel coordinates. It also emits a frame-start marker that neighbouring blocks, such as a pixel fetcher or a blender, use as the frame boundary. Each of the four timing outputs has its own polarity control.

Output is gated by two enables:
- The immediate video enable stops all output at once.
- The frame-qualified enable is sampled only at a frame boundary. It therefore starts a frame cleanly, and when cleared it lets the current frame finish.

The segment lengths are captured into shadow registers at every frame start. Software may rewrite them at any time without tearing the frame that is being shown.

Top module: `rgb_timing_gen`

## Requirements
- R1: While reset is low and after its release with the enables low, hsync, vsync, de and frame_start are at their inactive level (low with the inversion bits at 0), and pix_x and pix_y are 0.
- R2: With clk_div_sel at 0 or clk_div_m1 at 0, pix_ce is high on every clock. Otherwise pix_ce is high on one clock in every clk_div_m1+1 clocks; call this pixel period P.
- R3: Each line starts with hs_width_m1+1 pixels of active hsync, followed by h_back_m1+1 pixels of back porch, then h_active_m1+1 pixels with de active, then h_front_m1+1 pixels of front porch. The first pixel with de active in a frame comes P*((vs_width_m1+v_back_m1+2)*HT + hs_width_m1+h_back_m1+2) clocks after frame start, where HT is the sum of the four horizontal counts.
- R4: Each frame contains vs_width_m1+1 lines of active vsync, v_back_m1+1 back porch lines, v_active_m1+1 lines carrying de and v_front_m1+1 front porch lines. A running frame lasts exactly P*HT*VT clocks, and de is active for P*(h_active_m1+1)*(v_active_m1+1) clocks per frame.
- R5: pix_x counts 0 to h_active_m1 across the active columns and pix_y counts 0 to v_active_m1 across the active lines. Both are 0 outside those regions, and they change only on a pixel enable.
- R6: frame_start is high for exactly one pixel period, on the first pixel of the first vsync line, while both hsync and vsync are active.
- R7: inv_hsync, inv_vsync and inv_de each invert their output, idle level included. pclk_out equals pix_ce XOR inv_pclk.
- R8: Output starts only when cfg_video_on and cfg_frame_on are both high. It starts on a pixel enable and its first pixel is the frame-start pixel.
- R9: cfg_frame_on is sampled only at frame boundaries. Clearing it mid-frame lets the current frame run to its end, after which all outputs stay idle.
- R10: Clearing cfg_video_on puts all outputs in the idle state and pix_x and pix_y at 0 on the next clock. Setting it again starts a fresh frame from the sync pixel.
- R11: The eight segment fields are captured at each frame start. A change written mid-frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_video_on | input | 1 | Immediate video enable |
| cfg_frame_on | input | 1 | Frame-qualified enable, sampled at frame boundaries |
| hs_width_m1 | input | CNT_W | Hsync width in pixels minus one |
| h_back_m1 | input | CNT_W | Horizontal back porch minus one |
| h_active_m1 | input | CNT_W | Active width minus one |
| h_front_m1 | input | CNT_W | Horizontal front porch minus one |
| vs_width_m1 | input | CNT_W | Vsync width in lines minus one |
| v_back_m1 | input | CNT_W | Vertical back porch minus one |
| v_active_m1 | input | CNT_W | Active height minus one |
| v_front_m1 | input | CNT_W | Vertical front porch minus one |
| inv_hsync | input | 1 | Invert hsync |
| inv_vsync | input | 1 | Invert vsync |
| inv_de | input | 1 | Invert data-enable |
| inv_pclk | input | 1 | Invert pixel clock output |
| clk_div_m1 | input | DIV_W | Pixel clock divisor minus one |
| clk_div_sel | input | 1 | 1 selects divided clock, 0 the system clock |
| pix_ce | output | 1 | Pixel clock enable |
| pclk_out | output | 1 | Pixel clock strobe after polarity |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data-enable |
| pix_x | output | CNT_W | Active column index |
| pix_y | output | CNT_W | Active line index |
| frame_start | output | 1 | First pixel of a frame |

## Verification
The raster counters and the run flag update on the clock edge that carries pix_ce. The outputs are decoded combinationally from those registers, so every output reflects a pixel step in the same clock that follows that edge, and it holds for the P clocks of that pixel. The bench drives and samples only on the falling edge. From a sample where frame_start is high it counts every clock of the frame. It checks pulse lengths, de totals and the first de position as clock counts of P times the programmed fields plus one. After a frame-qualified start, frame_start is expected within P+1 clocks. After the immediate enable drops, the idle levels are expected at the very next sample.

// File: rtl/tg_pkg.sv
// Shared types for the RGB timing generator.
// Assumes both raster axes use the same four-segment order.
package tg_pkg;
    localparam int unsigned TG_PHASES = 4;
    localparam int unsigned TG_AXES   = 2;

    // Segment order within a line or a frame; the order is behaviour.
    typedef enum logic [1:0] {
        PH_SYNC  = 2'd0,
        PH_BACK  = 2'd1,
        PH_ACT   = 2'd2,
        PH_FRONT = 2'd3
    } tg_phase_e;
endpackage

// File: rtl/tg_pixclk_div.sv
// Pixel clock enable generator.
// Divides the system clock by div_m1+1 when div_sel is set and div_m1 is
// non-zero; otherwise the enable is high on every clock. The counter runs
// freely and wraps safely if div_m1 shrinks while it counts.
module tg_pixclk_div #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_sel,
    input  logic [DIV_W-1:0] div_m1,
    output logic             pix_ce
);
    logic [DIV_W-1:0] div_cnt;
    logic             bypass;
    logic             at_top;

    // Decide between direct and divided clock.
    always_comb begin
        bypass = !div_sel || (div_m1 == '0);
        at_top = (div_cnt >= div_m1);
        pix_ce = bypass || at_top;
    end

    // Free-running divider count, cleared at the top of each period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (bypass || at_top) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tg_axis_counter.sv
// One raster axis: walks sync, back porch, active and front porch segments,
// each len_m1[segment]+1 steps long. Holds the sync start while clear is high.
// Assumes the lengths stay stable while stepping (the top shadows them).
module tg_axis_counter
    import tg_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [CNT_W-1:0] len_m1 [TG_PHASES],
    output tg_phase_e        phase,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last
);
    logic seg_end;

    // End of the current segment and end of the whole axis period.
    always_comb begin
        seg_end = (cnt >= len_m1[phase]);
        at_last = seg_end && (phase == PH_FRONT);
    end

    // Segment and position update on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            phase <= PH_SYNC;
            cnt   <= '0;
        end else if (step) begin
            if (seg_end) begin
                phase <= tg_phase_e'(phase + 2'd1);
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tg_out_decode.sv
// Decodes panel-facing signals from the raster state.
// Purely combinational; its inputs are all registers, so outputs are clean.
// Idle (run low) drives the inactive level of every signal.
module tg_out_decode
    import tg_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             run,
    input  logic             pix_ce,
    input  tg_phase_e        h_phase,
    input  logic [CNT_W-1:0] h_cnt,
    input  tg_phase_e        v_phase,
    input  logic [CNT_W-1:0] v_cnt,
    input  logic             inv_hsync,
    input  logic             inv_vsync,
    input  logic             inv_de,
    input  logic             inv_pclk,
    output logic             pclk_out,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [CNT_W-1:0] pix_x,
    output logic [CNT_W-1:0] pix_y,
    output logic             frame_start
);
    logic hs_act, vs_act, de_act, h_in_act, v_in_act;

    // Raw activity of each signal, then polarity.
    always_comb begin
        h_in_act    = run && (h_phase == PH_ACT);
        v_in_act    = run && (v_phase == PH_ACT);
        hs_act      = run && (h_phase == PH_SYNC);
        vs_act      = run && (v_phase == PH_SYNC);
        de_act      = h_in_act && v_in_act;
        hsync       = hs_act ^ inv_hsync;
        vsync       = vs_act ^ inv_vsync;
        de          = de_act ^ inv_de;
        pclk_out    = pix_ce ^ inv_pclk;
        pix_x       = h_in_act ? h_cnt : '0;
        pix_y       = v_in_act ? v_cnt : '0;
        frame_start = hs_act && vs_act && (h_cnt == '0) && (v_cnt == '0);
    end
endmodule

// File: rtl/rgb_timing_gen.sv
// Parallel RGB panel timing generator (top).
// Runs a horizontal and a vertical segment counter on a divided pixel
// enable, shadows the segment lengths at each frame start, and gates output
// with an immediate enable and a frame-qualified enable.
// Assumes all fields are programmed as count minus one.
module rgb_timing_gen
    import tg_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_video_on,
    input  logic             cfg_frame_on,
    input  logic [CNT_W-1:0] hs_width_m1,
    input  logic [CNT_W-1:0] h_back_m1,
    input  logic [CNT_W-1:0] h_active_m1,
    input  logic [CNT_W-1:0] h_front_m1,
    input  logic [CNT_W-1:0] vs_width_m1,
    input  logic [CNT_W-1:0] v_back_m1,
    input  logic [CNT_W-1:0] v_active_m1,
    input  logic [CNT_W-1:0] v_front_m1,
    input  logic             inv_hsync,
    input  logic             inv_vsync,
    input  logic             inv_de,
    input  logic             inv_pclk,
    input  logic [DIV_W-1:0] clk_div_m1,
    input  logic             clk_div_sel,
    output logic             pix_ce,
    output logic             pclk_out,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [CNT_W-1:0] pix_x,
    output logic [CNT_W-1:0] pix_y,
    output logic             frame_start
);
    localparam int unsigned AX_H = 0;
    localparam int unsigned AX_V = TG_AXES - 1;

    logic [CNT_W-1:0] live_len [TG_AXES][TG_PHASES];
    logic [CNT_W-1:0] sh_len   [TG_AXES][TG_PHASES];

    logic             run, run_n;
    logic             frame_end, keep_going, start_go, shadow_load;
    logic             cnt_clear, h_step, v_step, h_last, v_last;
    tg_phase_e        h_phase, v_phase;
    logic [CNT_W-1:0] h_cnt, v_cnt;

    // Group the programmed fields by axis and segment order.
    always_comb begin
        live_len[AX_H][PH_SYNC]  = hs_width_m1;
        live_len[AX_H][PH_BACK]  = h_back_m1;
        live_len[AX_H][PH_ACT]   = h_active_m1;
        live_len[AX_H][PH_FRONT] = h_front_m1;
        live_len[AX_V][PH_SYNC]  = vs_width_m1;
        live_len[AX_V][PH_BACK]  = v_back_m1;
        live_len[AX_V][PH_ACT]   = v_active_m1;
        live_len[AX_V][PH_FRONT] = v_front_m1;
    end

    tg_pixclk_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_sel(clk_div_sel),
        .div_m1 (clk_div_m1),
        .pix_ce (pix_ce)
    );

    // Run control: immediate stop, qualified start and frame-end stop.
    always_comb begin
        keep_going  = cfg_video_on && cfg_frame_on;
        frame_end   = run && pix_ce && h_last && v_last;
        start_go    = !run && keep_going && pix_ce;
        shadow_load = start_go || (frame_end && keep_going);
        if (!cfg_video_on) begin
            run_n = 1'b0;
        end else if (!run) begin
            run_n = start_go;
        end else if (frame_end) begin
            run_n = keep_going;
        end else begin
            run_n = 1'b1;
        end
        cnt_clear = !run || !cfg_video_on;
        h_step    = run && pix_ce;
        v_step    = h_step && h_last;
    end

    // Run flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
        end else begin
            run <= run_n;
        end
    end

    // Shadow copy of segment lengths, taken at each frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < TG_AXES; a++) begin
                for (int p = 0; p < TG_PHASES; p++) begin
                    sh_len[a][p] <= '0;
                end
            end
        end else if (shadow_load) begin
            for (int a = 0; a < TG_AXES; a++) begin
                for (int p = 0; p < TG_PHASES; p++) begin
                    sh_len[a][p] <= live_len[a][p];
                end
            end
        end
    end

    tg_axis_counter #(.CNT_W(CNT_W)) u_hcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .step   (h_step),
        .len_m1 (sh_len[AX_H]),
        .phase  (h_phase),
        .cnt    (h_cnt),
        .at_last(h_last)
    );

    tg_axis_counter #(.CNT_W(CNT_W)) u_vcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cnt_clear),
        .step   (v_step),
        .len_m1 (sh_len[AX_V]),
        .phase  (v_phase),
        .cnt    (v_cnt),
        .at_last(v_last)
    );

    tg_out_decode #(.CNT_W(CNT_W)) u_dec (
        .run        (run),
        .pix_ce     (pix_ce),
        .h_phase    (h_phase),
        .h_cnt      (h_cnt),
        .v_phase    (v_phase),
        .v_cnt      (v_cnt),
        .inv_hsync  (inv_hsync),
        .inv_vsync  (inv_vsync),
        .inv_de     (inv_de),
        .inv_pclk   (inv_pclk),
        .pclk_out   (pclk_out),
        .hsync      (hsync),
        .vsync      (vsync),
        .de         (de),
        .pix_x      (pix_x),
        .pix_y      (pix_y),
        .frame_start(frame_start)
    );
endmodule

// File: rtl/tg_checks.sv
// Property checker for rgb_timing_gen, attached with bind.
// Observes ports only; every property is disabled during reset.
module tg_checks #(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned DIV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_video_on,
    input logic             clk_div_sel,
    input logic [DIV_W-1:0] clk_div_m1,
    input logic             inv_hsync,
    input logic             inv_vsync,
    input logic             inv_de,
    input logic             pix_ce,
    input logic             hsync,
    input logic             vsync,
    input logic             de,
    input logic [CNT_W-1:0] pix_x,
    input logic             frame_start
);
    // A divided enable is never high on two clocks in a row.
    assert_divided_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_div_sel && (clk_div_m1 != '0) && pix_ce)
        |=> (!pix_ce || !clk_div_sel || !$stable(clk_div_m1)));

    // Data-enable never overlaps a sync pulse.
    assert_de_clear_of_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (de != inv_de) |-> ((hsync == inv_hsync) && (vsync == inv_vsync)));

    // Frame start lies inside both sync pulses.
    assert_start_in_sync_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> ((hsync != inv_hsync) && (vsync != inv_vsync)));

    // Column index moves only on a pixel enable or an immediate stop.
    assert_x_on_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_ce && cfg_video_on) |=> $stable(pix_x));

    // Dropping the immediate enable idles the outputs on the next clock.
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_video_on |=> ((de == inv_de) && (hsync == inv_hsync)
                           && (vsync == inv_vsync) && !frame_start));
endmodule

bind rgb_timing_gen tg_checks #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tg_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_video_on(cfg_video_on),
    .clk_div_sel (clk_div_sel),
    .clk_div_m1  (clk_div_m1),
    .inv_hsync   (inv_hsync),
    .inv_vsync   (inv_vsync),
    .inv_de      (inv_de),
    .pix_ce      (pix_ce),
    .hsync       (hsync),
    .vsync       (vsync),
    .de          (de),
    .pix_x       (pix_x),
    .frame_start (frame_start)
);

// File: tb/test_rgb_timing_gen.sv
`timescale 1ns/1ps
module test_rgb_timing_gen;
    localparam int unsigned CW = 12;
    localparam int unsigned DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_video_on = 1'b0, cfg_frame_on = 1'b0;
    logic [CW-1:0] hs_width_m1 = '0, h_back_m1 = '0, h_active_m1 = '0, h_front_m1 = '0;
    logic [CW-1:0] vs_width_m1 = '0, v_back_m1 = '0, v_active_m1 = '0, v_front_m1 = '0;
    logic          inv_hsync = 1'b0, inv_vsync = 1'b0, inv_de = 1'b0, inv_pclk = 1'b0;
    logic [DW-1:0] clk_div_m1 = '0;
    logic          clk_div_sel = 1'b0;
    logic          pix_ce, pclk_out, hsync, vsync, de, frame_start;
    logic [CW-1:0] pix_x, pix_y;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    int b_hsw, b_hbp, b_hact, b_hfp, b_vsw, b_vbp, b_vact, b_vfp, b_div;
    bit b_dsel, b_ih, b_iv, b_id, b_ip;

    always #2.5 clk = ~clk;

    rgb_timing_gen #(.CNT_W(CW), .DIV_W(DW)) i_rgb_timing_gen (
        .clk(clk), .rst_n(rst_n), .cfg_video_on(cfg_video_on), .cfg_frame_on(cfg_frame_on),
        .hs_width_m1(hs_width_m1), .h_back_m1(h_back_m1), .h_active_m1(h_active_m1),
        .h_front_m1(h_front_m1), .vs_width_m1(vs_width_m1), .v_back_m1(v_back_m1),
        .v_active_m1(v_active_m1), .v_front_m1(v_front_m1), .inv_hsync(inv_hsync),
        .inv_vsync(inv_vsync), .inv_de(inv_de), .inv_pclk(inv_pclk), .clk_div_m1(clk_div_m1),
        .clk_div_sel(clk_div_sel), .pix_ce(pix_ce), .pclk_out(pclk_out), .hsync(hsync),
        .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y), .frame_start(frame_start)
    );

    // Expected pixel period and raster totals from the programmed fields.
    function automatic int per();
        return (b_dsel && b_div != 0) ? b_div + 1 : 1;
    endfunction
    function automatic int htot();
        return b_hsw + b_hbp + b_hact + b_hfp + 4;
    endfunction
    function automatic int vtot();
        return b_vsw + b_vbp + b_vact + b_vfp + 4;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply_cfg();
        hs_width_m1 = CW'(b_hsw);  h_back_m1 = CW'(b_hbp);
        h_active_m1 = CW'(b_hact); h_front_m1 = CW'(b_hfp);
        vs_width_m1 = CW'(b_vsw);  v_back_m1 = CW'(b_vbp);
        v_active_m1 = CW'(b_vact); v_front_m1 = CW'(b_vfp);
        clk_div_m1 = DW'(b_div);   clk_div_sel = b_dsel;
        inv_hsync = b_ih; inv_vsync = b_iv; inv_de = b_id; inv_pclk = b_ip;
    endtask

    // Count of outputs away from their idle level at this sample.
    function automatic int busy_now();
        return int'(de ^ b_id) + int'(hsync ^ b_ih) + int'(vsync ^ b_iv) + int'(frame_start);
    endfunction

    task automatic wait_fs(input int limit, output bit found);
        found = 1'b0;
        for (int i = 0; i <= limit; i++) begin
            if (frame_start) begin
                found = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    // Pixel enable spacing and pixel clock strobe polarity.
    task automatic check_div();
        int gap = 0;
        int bad = 0;
        for (int i = 0; i < 20 && !pix_ce; i++) @(negedge clk);
        do begin
            if (pclk_out !== (pix_ce ^ b_ip)) bad++;
            @(negedge clk);
            gap++;
        end while (!pix_ce && gap < 40);
        chk("R2 pix_ce period", gap, per());
        chk("R7 pclk polarity", bad, 0);
    endtask

    // Walk one frame from a frame_start sample and count its features.
    task automatic measure_frame(input int chg_hact, input bit drop, input bit expect_next);
        int p = per();
        int ht = htot();
        int vt = vtot();
        int fl = p * ht * vt;
        int e_de = p * (b_hact + 1) * (b_vact + 1);
        int e_hs = p * (b_hsw + 1) * vt;
        int e_vs = p * ht * (b_vsw + 1);
        int e_hrun = p * (b_hsw + 1);
        int e_fde = p * ((b_vsw + b_vbp + 2) * ht + b_hsw + b_hbp + 2);
        int e_mx = b_hact;
        int e_my = b_vact;
        int n_de = 0, n_hs = 0, n_vs = 0, n_fs = 0, hrun = 0, fde = -1;
        int mx = 0, my = 0, x0 = -1, y0 = -1, pbad = 0, idle_bad = 0;
        bit hopen = 1'b1;
        for (int i = 0; i < fl; i++) begin
            if (de ^ b_id) begin
                n_de++;
                if (fde < 0) begin fde = i; x0 = int'(pix_x); y0 = int'(pix_y); end
                if (int'(pix_x) > mx) mx = int'(pix_x);
                if (int'(pix_y) > my) my = int'(pix_y);
            end
            if (hsync ^ b_ih) begin
                n_hs++;
                if (hopen) hrun++;
            end else begin
                hopen = 1'b0;
            end
            if (vsync ^ b_iv) n_vs++;
            if (frame_start) n_fs++;
            if (pclk_out !== (pix_ce ^ b_ip)) pbad++;
            if (i == 3) begin
                if (chg_hact >= 0) begin
                    b_hact = chg_hact;
                    h_active_m1 = CW'(chg_hact);
                end
                if (drop) cfg_frame_on = 1'b0;
            end
            @(negedge clk);
        end
        chk("R4 de clocks per frame", n_de, e_de);
        chk("R3 hsync clocks per frame", n_hs, e_hs);
        chk("R3 first hsync pulse width", hrun, e_hrun);
        chk("R4 vsync clocks per frame", n_vs, e_vs);
        chk("R6 frame_start width", n_fs, p);
        chk("R3 first de position", fde, e_fde);
        chk("R5 max pix_x", mx, e_mx);
        chk("R5 max pix_y", my, e_my);
        chk("R5 first active pixel x", x0, 0);
        chk("R5 first active pixel y", y0, 0);
        chk("R7 pclk polarity in frame", pbad, 0);
        if (expect_next) begin
            chk("R4 next frame starts after frame length", int'(frame_start), 1);
        end else begin
            for (int i = 0; i < fl; i++) begin
                idle_bad += busy_now();
                @(negedge clk);
            end
            chk("R9 idle after finished frame", idle_bad, 0);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit found;
        int bad;
        void'($urandom(32'd20240611));
        b_hsw = 0; b_hbp = 0; b_hact = 0; b_hfp = 0; b_vsw = 0; b_vbp = 0;
        b_vact = 0; b_vfp = 0; b_div = 0; b_dsel = 0;
        b_ih = 0; b_iv = 0; b_id = 0; b_ip = 0;
        repeat (3) @(negedge clk);
        chk("R1 idle during reset", busy_now() + int'(pix_x) + int'(pix_y), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R1 idle after reset", busy_now() + int'(pix_x) + int'(pix_y), 0);

        // Directed configuration with a divided clock.
        b_hsw = 1; b_hbp = 2; b_hact = 5; b_hfp = 0;
        b_vsw = 0; b_vbp = 1; b_vact = 2; b_vfp = 1;
        b_div = 2; b_dsel = 1;
        apply_cfg();
        @(negedge clk);
        check_div();

        // Frame enable low: no output even with the video enable high.
        cfg_video_on = 1'b1;
        bad = 0;
        for (int i = 0; i < 50; i++) begin
            bad += busy_now();
            @(negedge clk);
        end
        chk("R8 no output without frame enable", bad, 0);
        cfg_frame_on = 1'b1;
        wait_fs(per() + 1, found);
        chk("R8 start within one pixel period", int'(found), 1);
        measure_frame(-1, 1'b0, 1'b1);
        // Mid-frame width change: old width for this frame, new for the next.
        measure_frame(2, 1'b0, 1'b1);
        chk("R11 new width applied from next frame", int'(h_active_m1), 2);
        measure_frame(-1, 1'b0, 1'b1);
        // Clear the frame enable mid-frame: the frame completes, then idle.
        measure_frame(-1, 1'b1, 1'b0);

        // Immediate stop and restart.
        cfg_frame_on = 1'b1;
        wait_fs(per() + 1, found);
        chk("R8 restart with frame enable", int'(found), 1);
        repeat (7) @(negedge clk);
        cfg_video_on = 1'b0;
        @(negedge clk);
        chk("R10 idle on next clock", busy_now() + int'(pix_x) + int'(pix_y), 0);
        cfg_video_on = 1'b1;
        wait_fs(per() + 1, found);
        chk("R10 fresh frame after re-enable", int'(found), 1);
        measure_frame(-1, 1'b0, 1'b1);

        // Bypass cases with all polarities inverted.
        cfg_video_on = 1'b0;
        b_dsel = 0; b_div = 5; b_ih = 1; b_iv = 1; b_id = 1; b_ip = 1;
        apply_cfg();
        @(negedge clk);
        chk("R7 inverted idle levels", busy_now(), 0);
        check_div();
        b_dsel = 1; b_div = 0;
        apply_cfg();
        @(negedge clk);
        check_div();
        cfg_video_on = 1'b1;
        wait_fs(2, found);
        chk("R8 start in bypass", int'(found), 1);
        measure_frame(-1, 1'b0, 1'b1);

        // Random configurations.
        for (int t = 0; t < 8; t++) begin
            cfg_video_on = 1'b0;
            b_hsw = int'($urandom % 4); b_hbp = int'($urandom % 4);
            b_hact = 1 + int'($urandom % 6); b_hfp = int'($urandom % 4);
            b_vsw = int'($urandom % 4); b_vbp = int'($urandom % 4);
            b_vact = int'($urandom % 4); b_vfp = int'($urandom % 4);
            b_div = int'($urandom % 4); b_dsel = 1'($urandom % 2);
            b_ih = 1'($urandom % 2); b_iv = 1'($urandom % 2);
            b_id = 1'($urandom % 2); b_ip = 1'($urandom % 2);
            apply_cfg();
            @(negedge clk);
            chk("R7 idle levels follow inversion", busy_now(), 0);
            check_div();
            cfg_video_on = 1'b1;
            cfg_frame_on = 1'b1;
            wait_fs(per() + 1, found);
            chk("R8 random start", int'(found), 1);
            measure_frame(-1, 1'b0, 1'b1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule